// File: doc/BRIEF.md
# Clock Gate Set/Clear Register Bank

This block holds the enable state for a group of gated clocks and exposes it to software through three word registers that share one bit position per gate. A status word reports which gates are running. A set alias turns on every gate whose bit is written as 1. A clear alias turns off every gate whose bit is written as 1. Software can therefore start or stop one clock without a read-modify-write that could race with another agent changing a different gate.

The bank sits on a simple synchronous register bus. Any number of write ports may be instantiated. Each write port carries a strobe, an address and a data word. One read port carries a strobe and an address and returns a registered data word. The outputs are enable levels, one per gated clock. They are meant to drive glitch-free gating cells placed elsewhere. At reset every gate takes a parameterized mask, which by default enables all gates.

Top module: `clk_gate_bank`

## Requirements
- R1: Immediately after reset, `gate_en` equals RESET_MASK (all ones by default) and `rd_data` is zero.
- R2: A write to BASE_ADDR+4 turns on every gate whose data bit is 1. Gates whose data bit is 0 keep their state.
- R3: A write to BASE_ADDR+8 turns off every gate whose data bit is 1. Gates whose data bit is 0 keep their state.
- R4: `gate_en` is registered. It still shows the old state during the write cycle and shows the new state after the next rising clock edge.
- R5: A read of BASE_ADDR returns the gate state in bits [NUM_GATES-1:0], with bit i set when gate i is on. All higher bits read zero. The value appears on `rd_data` after the clock edge that samples `rd_en`.
- R6: Reads of BASE_ADDR+4, BASE_ADDR+8 or any unmapped address return zero.
- R7: Writes to BASE_ADDR or to any unmapped address leave every gate unchanged. Data bits at positions NUM_GATES and above have no effect.
- R8: When one cycle carries a set on one write port and a clear on another for the same gate, the gate ends up off. Set and clear requests on different gates in the same cycle both take effect.
- R9: `rd_data` keeps its value in every cycle where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | NUM_WR_PORTS | Write strobe, one per write port |
| wr_addr | input | NUM_WR_PORTS*ADDR_W | Write byte addresses, with port p in slice [p*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_WR_PORTS*DATA_W | Write data, with port p in slice [p*DATA_W +: DATA_W] |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Registered read data |
| gate_en | output | NUM_GATES | Clock enable level, one per gate |

## Verification
The assertions assume that only bus strobes change gate state. They also assume that a clear request through port 0 never meets a set request of higher priority, because clear always wins. The bench drives every strobe, address and data word at the falling edge, away from the sampling edge, and holds them for exactly one cycle. Same-cycle conflicts are produced only by driving port 0 and port 1 together in one step. This way every assertion about a pair of ports sees a single, well-defined request set.

// File: rtl/cgb_pkg.sv
package cgb_pkg;

    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_SET    = 4;
    localparam int unsigned OFS_CLR    = 8;

    typedef enum logic [1:0] {
        RGN_NONE   = 2'd0,
        RGN_STATUS = 2'd1,
        RGN_SET    = 2'd2,
        RGN_CLR    = 2'd3
    } cgb_region_e;

    function automatic cgb_region_e cgb_classify(input logic [31:0] ofs);
        cgb_region_e r;
        case (ofs)
            OFS_STATUS: r = RGN_STATUS;
            OFS_SET:    r = RGN_SET;
            OFS_CLR:    r = RGN_CLR;
            default:    r = RGN_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cgb_wr_decode.sv
module cgb_wr_decode
    import cgb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_GATES = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [NUM_GATES-1:0] set_mask,
    output logic [NUM_GATES-1:0] clr_mask
);

    logic [ADDR_W-1:0] ofs;
    cgb_region_e       rgn;

    always_comb begin
        ofs      = wr_addr - BASE_ADDR;
        rgn      = cgb_classify(32'(ofs));
        set_mask = '0;
        clr_mask = '0;
        if (wr_en) begin
            if (rgn == RGN_SET) set_mask = wr_data[NUM_GATES-1:0];
            if (rgn == RGN_CLR) clr_mask = wr_data[NUM_GATES-1:0];
        end
    end

endmodule

// File: rtl/cgb_gate_state.sv
module cgb_gate_state #(
    parameter int unsigned NUM_GATES    = 16,
    parameter int unsigned NUM_WR_PORTS = 2,
    parameter logic [NUM_GATES-1:0] RESET_MASK = '1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_WR_PORTS*NUM_GATES-1:0] set_masks,
    input  logic [NUM_WR_PORTS*NUM_GATES-1:0] clr_masks,
    output logic [NUM_GATES-1:0]              gates
);

    typedef struct packed {
        logic [NUM_GATES-1:0] on;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic [NUM_GATES-1:0] set_any, clr_any;

    always_comb begin
        set_any = '0;
        clr_any = '0;
        for (int p = 0; p < int'(NUM_WR_PORTS); p++) begin
            set_any = set_any | set_masks[p*NUM_GATES +: NUM_GATES];
            clr_any = clr_any | clr_masks[p*NUM_GATES +: NUM_GATES];
        end
        st_d    = st_q;
        st_d.on = (st_q.on | set_any) & ~clr_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.on <= RESET_MASK;
        else        st_q    <= st_d;
    end

    assign gates = st_q.on;

endmodule

// File: rtl/cgb_rd_port.sv
module cgb_rd_port
    import cgb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_GATES = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [NUM_GATES-1:0] gates,
    output logic [DATA_W-1:0]    rd_data
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t rs_d, rs_q;
    logic [ADDR_W-1:0] ofs;

    always_comb begin
        ofs  = rd_addr - BASE_ADDR;
        rs_d = rs_q;
        if (rd_en) begin
            rs_d.data = '0;
            if (cgb_classify(32'(ofs)) == RGN_STATUS)
                rs_d.data[NUM_GATES-1:0] = gates;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rd_data = rs_q.data;

endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned NUM_GATES    = 16,
    parameter int unsigned NUM_WR_PORTS = 2,
    parameter logic [ADDR_W-1:0]    BASE_ADDR  = 8'h20,
    parameter logic [NUM_GATES-1:0] RESET_MASK = '1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_WR_PORTS-1:0]        wr_en,
    input  logic [NUM_WR_PORTS*ADDR_W-1:0] wr_addr,
    input  logic [NUM_WR_PORTS*DATA_W-1:0] wr_data,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_data,
    output logic [NUM_GATES-1:0]           gate_en
);

    localparam int unsigned MASK_W = NUM_WR_PORTS * NUM_GATES;

    logic [MASK_W-1:0] set_masks, clr_masks;

    for (genvar p = 0; p < NUM_WR_PORTS; p++) begin : g_wr
        cgb_wr_decode #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W),
            .NUM_GATES(NUM_GATES), .BASE_ADDR(BASE_ADDR)
        ) u_dec (
            .wr_en   (wr_en[p]),
            .wr_addr (wr_addr[p*ADDR_W +: ADDR_W]),
            .wr_data (wr_data[p*DATA_W +: DATA_W]),
            .set_mask(set_masks[p*NUM_GATES +: NUM_GATES]),
            .clr_mask(clr_masks[p*NUM_GATES +: NUM_GATES])
        );
    end

    cgb_gate_state #(
        .NUM_GATES(NUM_GATES), .NUM_WR_PORTS(NUM_WR_PORTS),
        .RESET_MASK(RESET_MASK)
    ) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_masks(set_masks),
        .clr_masks(clr_masks),
        .gates    (gate_en)
    );

    cgb_rd_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .NUM_GATES(NUM_GATES), .BASE_ADDR(BASE_ADDR)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .gates  (gate_en),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/cgb_checker.sv
module cgb_checker #(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned NUM_GATES    = 16,
    parameter int unsigned NUM_WR_PORTS = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_WR_PORTS-1:0]        wr_en,
    input logic [NUM_WR_PORTS*ADDR_W-1:0] wr_addr,
    input logic [NUM_WR_PORTS*DATA_W-1:0] wr_data,
    input logic                           rd_en,
    input logic [ADDR_W-1:0]              rd_addr,
    input logic [DATA_W-1:0]              rd_data,
    input logic [NUM_GATES-1:0]           gate_en
);

    localparam logic [ADDR_W-1:0] A_SET = BASE_ADDR + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_CLR = BASE_ADDR + ADDR_W'(8);

    logic                 p0_set, p0_clr, any_clr;
    logic [NUM_GATES-1:0] p0_bits;
    logic [DATA_W-1:0]    status_word;

    always_comb begin
        p0_bits = wr_data[NUM_GATES-1:0];
        p0_set  = wr_en[0] && (wr_addr[ADDR_W-1:0] == A_SET);
        p0_clr  = wr_en[0] && (wr_addr[ADDR_W-1:0] == A_CLR);
        any_clr = 1'b0;
        for (int p = 0; p < int'(NUM_WR_PORTS); p++)
            if (wr_en[p] && (wr_addr[p*ADDR_W +: ADDR_W] == A_CLR)) any_clr = 1'b1;
        status_word = '0;
        status_word[NUM_GATES-1:0] = gate_en;
    end

    // R7
    idle_bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) |=> $stable(gate_en));

    // R3
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p0_clr |=> ((gate_en & $past(p0_bits)) == '0));

    // R2
    set_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_set && !any_clr) |=> ((gate_en & $past(p0_bits)) == $past(p0_bits)));

    // R6
    alias_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != BASE_ADDR) |=> (rd_data == '0));

    // R5
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == BASE_ADDR) |=> (rd_data == $past(status_word)));

    // R9
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind clk_gate_bank cgb_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_GATES(NUM_GATES),
    .NUM_WR_PORTS(NUM_WR_PORTS), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .gate_en(gate_en)
);

// File: tb/sim_clk_gate_bank.sv
`timescale 1ns/1ps
module sim_clk_gate_bank;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NG = 16;
    localparam int NP = 2;
    localparam logic [AW-1:0] BASE = 8'h20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     wr_en = '0;
    logic [NP*AW-1:0]  wr_addr = '0;
    logic [NP*DW-1:0]  wr_data = '0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic [DW-1:0]     rd_data;
    logic [NG-1:0]     gate_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clk_gate_bank #(
        .ADDR_W(AW), .DATA_W(DW), .NUM_GATES(NG),
        .NUM_WR_PORTS(NP), .BASE_ADDR(BASE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .gate_en(gate_en)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_wr(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en[p] = 1'b1;
        wr_addr[p*AW +: AW] = a;
        wr_data[p*DW +: DW] = d;
    endtask

    task automatic end_cycle();
        @(negedge clk);
        wr_en = '0;
        rd_en = 1'b0;
    endtask

    task automatic write1(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        drive_wr(0, a, d);
        end_cycle();
    endtask

    task automatic read1(input logic [AW-1:0] a);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        end_cycle();
    endtask

    task automatic t_reset();
        check("R1 gate_en", 32'(gate_en), 32'h0000FFFF);
        check("R1 rd_data", rd_data, 32'h0);
    endtask

    task automatic t_clear_and_timing();
        @(negedge clk);
        drive_wr(0, BASE + 8'd8, 32'h000000F0);
        #1 check("R4 before edge", 32'(gate_en), 32'h0000FFFF);
        end_cycle();
        check("R3 clear bits", 32'(gate_en), 32'h0000FF0F);
    endtask

    task automatic t_set();
        write1(BASE + 8'd4, 32'h00000030);
        check("R2 set bits", 32'(gate_en), 32'h0000FF3F);
        write1(BASE + 8'd4, 32'h0);
        check("R2 zero no effect", 32'(gate_en), 32'h0000FF3F);
        write1(BASE + 8'd8, 32'h0);
        check("R3 zero no effect", 32'(gate_en), 32'h0000FF3F);
    endtask

    task automatic t_status_read();
        write1(BASE + 8'd4, 32'hFFFF0000);
        check("R7 high bits ignored", 32'(gate_en), 32'h0000FF3F);
        read1(BASE);
        check("R5 status read", rd_data, 32'h0000FF3F);
    endtask

    task automatic t_alias_reads();
        read1(BASE + 8'd4);
        check("R6 set alias read", rd_data, 32'h0);
        read1(BASE);
        read1(BASE + 8'd8);
        check("R6 clear alias read", rd_data, 32'h0);
        read1(BASE);
        read1(BASE + 8'd12);
        check("R6 unmapped read", rd_data, 32'h0);
    endtask

    task automatic t_ignored_writes();
        write1(BASE, 32'h0);
        check("R7 status write", 32'(gate_en), 32'h0000FF3F);
        write1(BASE + 8'd12, 32'hFFFFFFFF);
        check("R7 unmapped write", 32'(gate_en), 32'h0000FF3F);
    endtask

    task automatic t_hold();
        read1(BASE);
        write1(BASE + 8'd8, 32'h0000FF00);
        check("R9 hold gates moved", 32'(gate_en), 32'h0000003F);
        check("R9 rd_data held", rd_data, 32'h0000FF3F);
    endtask

    task automatic t_conflict();
        write1(BASE + 8'd8, 32'h0000FFFF);
        check("R3 all off", 32'(gate_en), 32'h0);
        @(negedge clk);
        drive_wr(0, BASE + 8'd4, 32'h00000003);
        drive_wr(1, BASE + 8'd8, 32'h00000001);
        end_cycle();
        check("R8 clear wins p1", 32'(gate_en), 32'h00000002);
        @(negedge clk);
        drive_wr(0, BASE + 8'd8, 32'h00000022);
        drive_wr(1, BASE + 8'd4, 32'h00000060);
        end_cycle();
        check("R8 clear wins p0", 32'(gate_en), 32'h00000040);
        read1(BASE);
        check("R5 readback", rd_data, 32'h00000040);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clear_and_timing();
        t_set();
        t_status_read();
        t_alias_reads();
        t_ignored_writes();
        t_hold();
        t_conflict();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule